// File: doc/BRIEF.md
# Two-Phase Bootstrap Mailbox Doorbell

This block lets host software issue one management command to an embedded controller before any command rings exist. Software names a 16-byte aligned mailbox in host memory by writing a single 32-bit doorbell register twice. The first write carries the upper part of the mailbox address and has the phase select bit set. The second write carries the lower part and has the phase select bit clear. The block joins the two halves into a 64-bit address. It then sends a one-cycle start request, with that address, to the controller that runs the command.

Software learns about progress by reading the ready bit. After the first write, ready drops for one cycle and then rises again; that rise is the acknowledge that lets software send the second write. After the second write, ready stays low until the controller signals, on its done input, that the completion entry has been placed in the mailbox. Writes that break the sequence are dropped and set a sticky error flag.

Top module: `boot_mbox_doorbell`

## Requirements
- R1: After reset, ready reads as 1, the error flag is 0 and no start request is issued.
- R2: A read of the doorbell offset (byte 0x160 of the 4 KB page, bits [1:0] of the address ignored) returns ready in bit 0 and zeros in bits 31:1. A read of any other offset returns zero.
- R3: A doorbell write with bit 1 = 1, made while idle, is accepted. Ready reads 0 in the cycle after the write and 1 in the cycle after that.
- R4: A write with bit 1 = 0, made after the acknowledge of R3, produces a start pulse exactly one cycle wide in the cycle after the write. The command address is {upper bits 31:2, lower bits 31:2, 4'b0000}, and this address is held until the next accepted write.
- R5: Ready reads 0 from the accepted lower write until the done input is sampled high. It reads 1 in the cycle after that.
- R6: A write with bit 1 = 0 made while idle, or any doorbell write made in the acknowledge cycle of R3, sets the error flag, issues no start and causes no change of phase.
- R7: A doorbell write made while a command runs sets the error flag and leaves the command address and the busy state unchanged.
- R8: Writes to offsets other than the doorbell have no effect.
- R9: A second upper write made while waiting for the lower write replaces the stored upper bits and restarts the acknowledge.
- R10: The error flag stays set until reset. Completed commands do not clear it.
- R11: A done input that arrives while no command is running is ignored.
- R12: Bit 0 of written data has no effect on the command address or the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset within the doorbell page |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| cmd_start | output | 1 | One-cycle command start request |
| cmd_addr | output | 64 | Assembled mailbox address |
| cmd_done | input | 1 | Command finished and completion entry written |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
On every cycle the assertions check these properties: the start pulse is one cycle wide; a start comes only from the phase that waits for the lower write, and it comes with ready low; ready rises out of the busy phase only after done; the error flag is sticky; a doorbell write during a running command leaves the address alone and flags an error. Only the bench scenarios can show the values themselves. These are the exact address assembled from the two writes, the one-cycle ready dip that acknowledges the upper write, the replacement of the upper bits by a repeated upper write, and the fact that writes to other offsets and stray done pulses leave no trace.

// File: rtl/boot_mbox_pkg.sv
package boot_mbox_pkg;
  localparam int DB_WORD_W    = 32;
  localparam int DB_READY_BIT = 0;
  localparam int DB_PHASE_BIT = 1;
  localparam int DB_FIELD_LSB = 2;
  localparam int DB_FIELD_W   = DB_WORD_W - DB_FIELD_LSB;
  localparam int MBOX_ALIGN_W = 4;
  localparam int MBOX_ADDR_W  = 2 * DB_FIELD_W + MBOX_ALIGN_W;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_HI_ACCEPT = 2'd1,
    PH_HI_WAIT   = 2'd2,
    PH_BUSY      = 2'd3
  } phase_e;

  typedef struct packed {
    logic                  wr_hit;
    logic                  rd_hit;
    logic                  hi_sel;
    logic [DB_FIELD_W-1:0] field;
  } db_req_t;
endpackage

// File: rtl/boot_mbox_decode.sv
module boot_mbox_decode
  import boot_mbox_pkg::*;
#(
  parameter int PAGE_AW   = 12,
  parameter int DB_OFFSET = 'h160
) (
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [PAGE_AW-1:0]   addr,
  input  logic [DB_WORD_W-1:0] wdata,
  output db_req_t              req
);
  localparam logic [PAGE_AW-1:0] OFS = PAGE_AW'(DB_OFFSET);

  logic word_match;
  logic unused_bits;

  assign word_match  = (addr[PAGE_AW-1:2] == OFS[PAGE_AW-1:2]);
  assign unused_bits = ^{addr[1:0], wdata[DB_READY_BIT]};

  always_comb begin
    req.wr_hit = wr_en & word_match;
    req.rd_hit = rd_en & word_match;
    req.hi_sel = wdata[DB_PHASE_BIT];
    req.field  = wdata[DB_WORD_W-1:DB_FIELD_LSB];
  end
endmodule

// File: rtl/boot_mbox_fsm.sv
module boot_mbox_fsm
  import boot_mbox_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_hit,
  input  logic   hi_sel,
  input  logic   cmd_done,
  output phase_e phase,
  output logic   ready,
  output logic   ld_hi,
  output logic   ld_lo,
  output logic   start_q,
  output logic   err_q
);
  phase_e phase_q, phase_d;
  logic   start_d, err_set;

  always_comb begin
    phase_d = phase_q;
    ld_hi   = 1'b0;
    ld_lo   = 1'b0;
    start_d = 1'b0;
    err_set = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (wr_hit) begin
          if (hi_sel) begin
            ld_hi   = 1'b1;
            phase_d = PH_HI_ACCEPT;
          end else begin
            err_set = 1'b1;
          end
        end
      end
      PH_HI_ACCEPT: begin
        if (wr_hit) err_set = 1'b1;
        phase_d = PH_HI_WAIT;
      end
      PH_HI_WAIT: begin
        if (wr_hit) begin
          if (hi_sel) begin
            ld_hi   = 1'b1;
            phase_d = PH_HI_ACCEPT;
          end else begin
            ld_lo   = 1'b1;
            start_d = 1'b1;
            phase_d = PH_BUSY;
          end
        end
      end
      PH_BUSY: begin
        if (wr_hit)   err_set = 1'b1;
        if (cmd_done) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      start_q <= start_d;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign phase = phase_q;
  assign ready = (phase_q == PH_IDLE) || (phase_q == PH_HI_WAIT);

  // R4: start is a single-cycle pulse
  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R10: error flag never falls outside reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R5: leaving the busy phase needs done
  p_busy_exit_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && $past(phase_q == PH_BUSY)) |-> $past(cmd_done));
endmodule

// File: rtl/boot_mbox_addr.sv
module boot_mbox_addr
  import boot_mbox_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_hi,
  input  logic                   ld_lo,
  input  logic [DB_FIELD_W-1:0]  field,
  output logic [MBOX_ADDR_W-1:0] mbox_addr
);
  logic [DB_FIELD_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (ld_hi) begin
      hi_q <= field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (ld_lo) begin
      lo_q <= field;
    end
  end

  assign mbox_addr = {hi_q, lo_q, {MBOX_ALIGN_W{1'b0}}};
endmodule

// File: rtl/boot_mbox_doorbell.sv
module boot_mbox_doorbell
  import boot_mbox_pkg::*;
#(
  parameter int PAGE_AW   = 12,
  parameter int DB_OFFSET = 'h160
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic                   reg_rd_en,
  input  logic [PAGE_AW-1:0]     reg_addr,
  input  logic [DB_WORD_W-1:0]   reg_wdata,
  output logic [DB_WORD_W-1:0]   reg_rdata,
  output logic                   cmd_start,
  output logic [MBOX_ADDR_W-1:0] cmd_addr,
  input  logic                   cmd_done,
  output logic                   proto_err
);
  db_req_t req;
  phase_e  phase;
  logic    ready, ld_hi, ld_lo;

  boot_mbox_decode #(.PAGE_AW(PAGE_AW), .DB_OFFSET(DB_OFFSET)) u_decode (
    .wr_en (reg_wr_en),
    .rd_en (reg_rd_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .req   (req)
  );

  boot_mbox_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (req.wr_hit),
    .hi_sel   (req.hi_sel),
    .cmd_done (cmd_done),
    .phase    (phase),
    .ready    (ready),
    .ld_hi    (ld_hi),
    .ld_lo    (ld_lo),
    .start_q  (cmd_start),
    .err_q    (proto_err)
  );

  boot_mbox_addr u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_hi     (ld_hi),
    .ld_lo     (ld_lo),
    .field     (req.field),
    .mbox_addr (cmd_addr)
  );

  always_comb begin
    reg_rdata = '0;
    if (req.rd_hit) reg_rdata[DB_READY_BIT] = ready;
  end

  // R4: start only follows an accepted lower write, and ready is low with it
  p_start_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> ($past(phase) == PH_HI_WAIT) && !ready);

  // R7: a write during a running command changes no address and flags an error
  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BUSY && req.wr_hit) |=> ($stable(cmd_addr) && proto_err));

  // R6: a lower write while idle never starts a command
  p_idle_lo_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && req.wr_hit && !req.hi_sel) |=> (!cmd_start && proto_err));
endmodule

// File: tb/boot_mbox_doorbell_tb.sv
`timescale 1ns/1ps
module boot_mbox_doorbell_tb;
  localparam logic [11:0] DB  = 12'h160;
  localparam int          NV  = 4;
  localparam logic [63:0] VEC [NV] = '{
    {32'hFFFF_FFFC, 32'hFFFF_FFFC},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'h0000_0004, 32'h0000_0000},
    {32'hA5A5_A5A5, 32'h5A5A_5A5B}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, reg_rd_en, cmd_done;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmd_start, proto_err;
  logic [63:0] cmd_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boot_mbox_doorbell u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_start(cmd_start), .cmd_addr(cmd_addr), .cmd_done(cmd_done),
    .proto_err(proto_err)
  );

  function automatic logic [63:0] exp_addr(logic [31:0] hi, logic [31:0] lo);
    return {hi[31:2], lo[31:2], 4'h0};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_rd_en = 1'b1; reg_addr = a;
    #0.5 v = reg_rdata;
    reg_rd_en = 1'b0; reg_addr = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic done_pulse();
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_rd_en = 1'b0; cmd_done = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [63:0] held;
    do_reset();

    // R1 reset state
    rd(DB, v);
    chk("R1 ready", v, 32'h1);
    chk("R1 err", proto_err, 0);
    chk("R1 start", cmd_start, 0);
    // R2 other offset reads zero
    rd(12'h180, v);
    chk("R2 other offset", v, 0);

    // Vector walk: R3, R4, R5, R12
    for (int i = 0; i < NV; i++) begin
      logic [31:0] hi, lo;
      hi = VEC[i][63:32]; lo = VEC[i][31:0];
      wr(DB, hi | 32'h2);
      rd(DB, v); chk("R3 ack dip", v, 32'h0);
      @(negedge clk);
      rd(DB, v); chk("R3 ack", v, 32'h1);
      wr(DB, lo & ~32'h2);
      chk("R4 start", cmd_start, 1);
      chk("R4 R12 addr", cmd_addr, exp_addr(hi, lo));
      rd(DB, v); chk("R5 busy", v, 32'h0);
      @(negedge clk);
      chk("R4 pulse width", cmd_start, 0);
      repeat (3) @(negedge clk);
      rd(DB, v); chk("R5 still busy", v, 32'h0);
      chk("R4 addr held", cmd_addr, exp_addr(hi, lo));
      done_pulse();
      rd(DB, v); chk("R5 complete", v, 32'h1);
      chk("R12 no err", proto_err, 0);
    end

    // R11: stray done while idle, then a normal command still works
    done_pulse();
    rd(DB, v); chk("R11 ready", v, 32'h1);
    chk("R11 no start", cmd_start, 0);
    wr(DB, 32'h0000_0102);
    rd(DB, v); chk("R11 hi accepted", v, 32'h0);
    @(negedge clk);
    wr(DB, 32'h0000_0200);
    chk("R11 start", cmd_start, 1);
    done_pulse();

    // R9: repeated upper write replaces upper bits
    wr(DB, 32'h1111_1112);
    @(negedge clk);
    wr(DB, 32'h2222_2222);
    rd(DB, v); chk("R9 re-ack dip", v, 32'h0);
    @(negedge clk);
    wr(DB, 32'h3333_3330);
    chk("R9 addr", cmd_addr, exp_addr(32'h2222_2222, 32'h3333_3330));
    chk("R9 start", cmd_start, 1);

    // R7: upper write while busy is ignored and flagged
    @(negedge clk);
    held = cmd_addr;
    wr(DB, 32'hDEAD_BEEE);
    chk("R7 err", proto_err, 1);
    chk("R7 addr", cmd_addr, held);
    rd(DB, v); chk("R7 busy", v, 32'h0);
    chk("R7 no start", cmd_start, 0);
    done_pulse();
    rd(DB, v); chk("R7 complete", v, 32'h1);

    // R10: error stays through a clean command, reset clears it
    wr(DB, 32'h0000_0042);
    @(negedge clk);
    wr(DB, 32'h0000_0040);
    done_pulse();
    chk("R10 sticky", proto_err, 1);
    do_reset();
    chk("R10 cleared", proto_err, 0);

    // R6: lower write while idle
    wr(DB, 32'h0000_0080);
    chk("R6 idle lo err", proto_err, 1);
    chk("R6 idle lo start", cmd_start, 0);
    rd(DB, v); chk("R6 idle lo ready", v, 32'h1);
    do_reset();

    // R6: write in the acknowledge cycle
    wr(DB, 32'h0000_0006);
    wr(DB, 32'h0000_0010);
    chk("R6 ack-cycle err", proto_err, 1);
    chk("R6 ack-cycle start", cmd_start, 0);
    rd(DB, v); chk("R6 ack-cycle ready", v, 32'h1);
    @(negedge clk);
    chk("R6 ack-cycle still no start", cmd_start, 0);
    do_reset();

    // R8: writes elsewhere ignored (a following idle lower write must still error)
    wr(12'h180, 32'h0000_0006);
    rd(DB, v); chk("R8 no ack dip", v, 32'h1);
    @(negedge clk);
    wr(12'h15C, 32'h0000_0004);
    chk("R8 no start", cmd_start, 0);
    chk("R8 no err", proto_err, 0);
    wr(DB, 32'h0000_0008);
    chk("R8 phase still idle", proto_err, 1);
    chk("R8 addr untouched", cmd_addr, 64'h0);

    // R2: doorbell read shows only the ready bit
    do_reset();
    wr(DB, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(DB, v); chk("R2 read pattern", v, 32'h1);
    rd(12'h163, v); chk("R2 byte lanes", v, 32'h1);

    summary();
  end
endmodule